// File: doc/BRIEF.md
# Nanosecond Time-of-Day Counter with Alarms

The block keeps a 64-bit nanosecond time-of-day value for stamping packets. On every reference clock in which it is enabled, the value grows by a programmed whole-nanosecond step. A 32-bit fractional addend also accumulates on each such clock. When that accumulator carries out, the clock adds one extra nanosecond. This lets software trim the effective rate finely enough to cancel oscillator drift.

Two 64-bit alarm comparators watch the corrected time and raise sticky flags when it reaches a programmed future value. Two outputs are derived from the same advancing count:
- a one-clock pulse each time the elapsed time crosses a multiple of a programmed period;
- a divided clock that toggles after a programmed number of advancing clocks.

A load of the time value resets the phase of both outputs, so they stay aligned to the counter. Software reaches everything through a small word-wide write/read port. Reads are combinational.

Top module: `ns_time_core`

## Requirements
- R1: After reset the time, fractional accumulator, all registers and both event flags are zero, and `pulse_o`, `div_clk_o` and `alarm_o` are low.
- R2: On each clock with the enable set and no load, the fractional accumulator (32 bits) adds the addend at address 5. The time adds the step at address 4, plus one when that addition carries out of bit 31.
- R3: Address 2 stages the low time word. A write to address 3 loads {written word, staged low word} into the time at that edge, with priority over advancing. The same load clears the fractional accumulator, the pulse phase and the divider phase, and drives `div_clk_o` low.
- R4: Alarm i (i = 0 and 1) is held in two words: the low word at address 6+2i and the high word at 7+2i. Event flag i sets at the edge where the time moves from below the alarm value to at or above it. The flag is sticky, appears on `alarm_o[i]`, and reads back as bit i of address 1.
- R5: Writing 1 to bit i of address 1 clears event flag i, and writing 0 leaves it unchanged. An alarm value of zero never sets its flag.
- R6: With a nonzero period at address 10 that exceeds the step, `pulse_o` is high for exactly one clock after each edge at which the nanoseconds elapsed since the last load cross a multiple of the period. A period of zero gives no pulses.
- R7: With the divisor N at address 11 below 2, `div_clk_o` is held low. Otherwise it toggles once every N/2 (integer division) advancing clocks.
- R8: Bit 0 of address 0 is the enable. While it is 0, the time, the fractional accumulator, the pulse phase and the divider hold, and `pulse_o` stays low. Register writes and reads still work.
- R9: Reads return each register zero-extended. Address 2 returns the live time bits [31:0] and address 3 returns bits [63:32]. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address for write and read |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| time_o | output | 64 | Current time in nanoseconds |
| pulse_o | output | 1 | Periodic one-clock pulse |
| div_clk_o | output | 1 | Divided clock, phase aligned to loads |
| alarm_o | output | 2 | Sticky alarm event flags |

## Verification
A write, a load, an advance, a flag change and a pulse all appear on the outputs one clock edge after the inputs that cause them are sampled. Read data is combinational and is valid during the same cycle as its address. A setting written at one edge first governs the advance at the following edge. The bench drives its inputs just after each rising edge and updates its model at the rising edge from the pre-edge inputs. It then compares time, pulse, divided clock, flags and read data at every falling edge. In this way each result is compared in the cycle it is due.

// File: rtl/ns_time_pkg.sv
package ns_time_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;
  localparam int TIME_W  = 64;
  localparam int N_ALARM = 2;

  localparam logic [ADDR_W-1:0] ADR_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_EVENT = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_TLO   = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_THI   = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_STEP  = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_FRAC  = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_ALM   = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_PER   = 4'd10;
  localparam logic [ADDR_W-1:0] ADR_DIVN  = 4'd11;
endpackage

// File: rtl/ns_time_regs.sv
module ns_time_regs
  import ns_time_pkg::*;
#(
  parameter int STEP_W = 8,
  parameter int FRAC_W = 32,
  parameter int PER_W  = 32,
  parameter int DIV_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic [N_ALARM-1:0] flags_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              en_o,
  output logic [STEP_W-1:0] step_o,
  output logic [FRAC_W-1:0] addend_o,
  output logic [PER_W-1:0]  period_o,
  output logic [DIV_W-1:0]  divn_o,
  output logic [TIME_W-1:0] alm_o [N_ALARM],
  output logic              load_o,
  output logic [TIME_W-1:0] load_val_o,
  output logic [N_ALARM-1:0] clr_o
);
  localparam int HALF_W = TIME_W / 2;

  logic [HALF_W-1:0] lo_stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o       <= 1'b0;
      step_o     <= '0;
      addend_o   <= '0;
      period_o   <= '0;
      divn_o     <= '0;
      lo_stage_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        ADR_CTRL: en_o       <= wdata_i[0];
        ADR_TLO:  lo_stage_q <= wdata_i[HALF_W-1:0];
        ADR_STEP: step_o     <= wdata_i[STEP_W-1:0];
        ADR_FRAC: addend_o   <= wdata_i[FRAC_W-1:0];
        ADR_PER:  period_o   <= wdata_i[PER_W-1:0];
        ADR_DIVN: divn_o     <= wdata_i[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < N_ALARM; i++) begin : g_alm
    localparam logic [ADDR_W-1:0] ALO = ADDR_W'(ADR_ALM + 2*i);
    localparam logic [ADDR_W-1:0] AHI = ADDR_W'(ADR_ALM + 2*i + 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) alm_o[i] <= '0;
      else if (wr_en_i && addr_i == ALO) alm_o[i][HALF_W-1:0] <= wdata_i;
      else if (wr_en_i && addr_i == AHI) alm_o[i][TIME_W-1:HALF_W] <= wdata_i;
    end
  end

  assign load_o     = wr_en_i && (addr_i == ADR_THI);
  assign load_val_o = {wdata_i, lo_stage_q};
  assign clr_o      = (wr_en_i && addr_i == ADR_EVENT) ? wdata_i[N_ALARM-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADR_CTRL:  rdata_o = DATA_W'(en_o);
      ADR_EVENT: rdata_o = DATA_W'(flags_i);
      ADR_TLO:   rdata_o = time_i[HALF_W-1:0];
      ADR_THI:   rdata_o = time_i[TIME_W-1:HALF_W];
      ADR_STEP:  rdata_o = DATA_W'(step_o);
      ADR_FRAC:  rdata_o = DATA_W'(addend_o);
      ADR_PER:   rdata_o = DATA_W'(period_o);
      ADR_DIVN:  rdata_o = DATA_W'(divn_o);
      default: begin
        for (int i = 0; i < N_ALARM; i++) begin
          if (addr_i == ADDR_W'(ADR_ALM + 2*i))     rdata_o = alm_o[i][HALF_W-1:0];
          if (addr_i == ADDR_W'(ADR_ALM + 2*i + 1)) rdata_o = alm_o[i][TIME_W-1:HALF_W];
        end
      end
    endcase
  end
endmodule

// File: rtl/ns_time_count.sv
module ns_time_count
  import ns_time_pkg::*;
#(
  parameter int STEP_W = 8,
  parameter int FRAC_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [TIME_W-1:0] load_val_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [FRAC_W-1:0] addend_i,
  output logic [TIME_W-1:0] time_o,
  output logic [TIME_W-1:0] time_nxt_o,
  output logic [STEP_W:0]   inc_o
);
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W:0]   frac_sum;

  assign frac_sum = {1'b0, frac_q} + {1'b0, addend_i};
  assign inc_o    = {1'b0, step_i} + (STEP_W+1)'(frac_sum[FRAC_W]);

  always_comb begin
    if (load_i)    time_nxt_o = load_val_i;
    else if (en_i) time_nxt_o = time_o + TIME_W'(inc_o);
    else           time_nxt_o = time_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_o <= '0;
      frac_q <= '0;
    end else begin
      time_o <= time_nxt_o;
      if (load_i)    frac_q <= '0;
      else if (en_i) frac_q <= frac_sum[FRAC_W-1:0];
    end
  end

  a_r8_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(time_o));
  a_r2_step_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> ((time_o - $past(time_o)) == TIME_W'($past(step_i))) ||
                          ((time_o - $past(time_o)) == TIME_W'($past(step_i)) + 1));
  a_r3_load_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> time_o == $past(load_val_i));
endmodule

// File: rtl/ns_time_alarm.sv
module ns_time_alarm
  import ns_time_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] time_i,
  input  logic [TIME_W-1:0] time_nxt_i,
  input  logic [TIME_W-1:0] alm_i,
  input  logic              clr_i,
  output logic              flag_o
);
  logic hit;
  assign hit = (alm_i != '0) && (time_i < alm_i) && (time_nxt_i >= alm_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else         flag_o <= (flag_o && !clr_i) || hit;
  end

  a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  a_r5_zero_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alm_i == '0 && !flag_o) |=> !flag_o);
endmodule

// File: rtl/ns_time_wave.sv
module ns_time_wave #(
  parameter int STEP_W = 8,
  parameter int PER_W  = 32,
  parameter int DIV_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [STEP_W:0]   inc_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic [DIV_W-1:0]  divn_i,
  output logic              pulse_o,
  output logic              div_o
);
  logic [PER_W-1:0] ph_q;
  logic [PER_W:0]   ph_sum;
  logic [DIV_W-1:0] dcnt_q;
  logic [DIV_W-1:0] half;

  assign ph_sum = {1'b0, ph_q} + (PER_W+1)'(inc_i);
  assign half   = divn_i >> 1;

  // pulse phase: ns elapsed since load, modulo period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= '0;
      pulse_o <= 1'b0;
    end else if (load_i || period_i == '0) begin
      ph_q    <= '0;
      pulse_o <= 1'b0;
    end else if (en_i) begin
      if (ph_sum >= {1'b0, period_i}) begin
        ph_q    <= PER_W'(ph_sum - {1'b0, period_i});
        pulse_o <= 1'b1;
      end else begin
        ph_q    <= ph_sum[PER_W-1:0];
        pulse_o <= 1'b0;
      end
    end else begin
      pulse_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dcnt_q <= '0;
      div_o  <= 1'b0;
    end else if (load_i || divn_i < DIV_W'(2)) begin
      dcnt_q <= '0;
      div_o  <= 1'b0;
    end else if (en_i) begin
      if (dcnt_q >= half - 1'b1) begin
        dcnt_q <= '0;
        div_o  <= !div_o;
      end else begin
        dcnt_q <= dcnt_q + 1'b1;
      end
    end
  end

  a_r8_no_pulse_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pulse_o);
  a_r7_div_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (divn_i < DIV_W'(2)) |=> !div_o);
  a_r3_phase_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (!div_o && !pulse_o));
endmodule

// File: rtl/ns_time_core.sv
module ns_time_core
  import ns_time_pkg::*;
#(
  parameter int STEP_W = 8,
  parameter int FRAC_W = 32,
  parameter int PER_W  = 32,
  parameter int DIV_W  = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [3:0]   addr_i,
  input  logic [31:0]  wdata_i,
  output logic [31:0]  rdata_o,
  output logic [63:0]  time_o,
  output logic         pulse_o,
  output logic         div_clk_o,
  output logic [1:0]   alarm_o
);
  logic              en;
  logic [STEP_W-1:0] step;
  logic [FRAC_W-1:0] addend;
  logic [PER_W-1:0]  period;
  logic [DIV_W-1:0]  divn;
  logic [TIME_W-1:0] alm [N_ALARM];
  logic              load;
  logic [TIME_W-1:0] load_val;
  logic [N_ALARM-1:0] clr;
  logic [N_ALARM-1:0] flags;
  logic [TIME_W-1:0] time_q;
  logic [TIME_W-1:0] time_nxt;
  logic [STEP_W:0]   inc;

  ns_time_regs #(.STEP_W(STEP_W), .FRAC_W(FRAC_W), .PER_W(PER_W), .DIV_W(DIV_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .time_i(time_q), .flags_i(flags), .rdata_o,
    .en_o(en), .step_o(step), .addend_o(addend), .period_o(period), .divn_o(divn),
    .alm_o(alm), .load_o(load), .load_val_o(load_val), .clr_o(clr)
  );

  ns_time_count #(.STEP_W(STEP_W), .FRAC_W(FRAC_W)) u_count (
    .clk_i, .rst_ni, .en_i(en), .load_i(load), .load_val_i(load_val),
    .step_i(step), .addend_i(addend),
    .time_o(time_q), .time_nxt_o(time_nxt), .inc_o(inc)
  );

  for (genvar i = 0; i < N_ALARM; i++) begin : g_alarm
    ns_time_alarm u_alarm (
      .clk_i, .rst_ni, .time_i(time_q), .time_nxt_i(time_nxt),
      .alm_i(alm[i]), .clr_i(clr[i]), .flag_o(flags[i])
    );
  end

  ns_time_wave #(.STEP_W(STEP_W), .PER_W(PER_W), .DIV_W(DIV_W)) u_wave (
    .clk_i, .rst_ni, .en_i(en), .load_i(load), .inc_i(inc),
    .period_i(period), .divn_i(divn), .pulse_o, .div_o(div_clk_o)
  );

  assign time_o  = time_q;
  assign alarm_o = flags;
endmodule

// File: tb/ns_time_core_test.sv
module ns_time_core_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] time_v;
  logic        pulse, divc;
  logic [1:0]  alarm;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  ns_time_core uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .time_o(time_v), .pulse_o(pulse), .div_clk_o(divc), .alarm_o(alarm)
  );

  always #(CLK_P/2) clk = ~clk;

  // reference model state
  logic [63:0] m_time, m_alm0, m_alm1, m_el;
  logic [31:0] m_frac, m_add, m_per, m_divn, m_lo, m_dcnt;
  logic [7:0]  m_step;
  logic        m_en, m_pulse, m_div;
  logic [1:0]  m_flag;

  function automatic logic [31:0] mread(logic [3:0] a);
    case (a)
      4'd0:  return {31'd0, m_en};
      4'd1:  return {30'd0, m_flag};
      4'd2:  return m_time[31:0];
      4'd3:  return m_time[63:32];
      4'd4:  return {24'd0, m_step};
      4'd5:  return m_add;
      4'd6:  return m_alm0[31:0];
      4'd7:  return m_alm0[63:32];
      4'd8:  return m_alm1[31:0];
      4'd9:  return m_alm1[63:32];
      4'd10: return m_per;
      4'd11: return m_divn;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_time = '0; m_alm0 = '0; m_alm1 = '0; m_el = '0;
      m_frac = '0; m_add = '0; m_per = '0; m_divn = '0; m_lo = '0; m_dcnt = '0;
      m_step = '0; m_en = 0; m_pulse = 0; m_div = 0; m_flag = '0;
    end else begin
      logic [63:0] nt, ne;
      logic [32:0] fs;
      logic [63:0] inc;
      logic ld;
      logic [1:0] hit, clr;
      fs  = {1'b0, m_frac} + {1'b0, m_add};
      inc = 64'(m_step) + 64'(fs[32]);
      ld  = wr_en && addr == 4'd3;
      if (ld)        nt = {wdata, m_lo};
      else if (m_en) nt = m_time + inc;
      else           nt = m_time;
      hit[0] = m_alm0 != 0 && m_time < m_alm0 && nt >= m_alm0;
      hit[1] = m_alm1 != 0 && m_time < m_alm1 && nt >= m_alm1;
      clr = (wr_en && addr == 4'd1) ? wdata[1:0] : 2'b00;
      m_flag = (m_flag & ~clr) | hit;
      if (ld || m_per == 0) begin
        m_el = 0; m_pulse = 0;
      end else if (m_en) begin
        ne = m_el + inc;
        m_pulse = (ne / 64'(m_per)) != (m_el / 64'(m_per));
        m_el = ne;
      end else m_pulse = 0;
      if (ld || m_divn < 2) begin
        m_dcnt = 0; m_div = 0;
      end else if (m_en) begin
        if (m_dcnt + 1 >= m_divn / 2) begin m_dcnt = 0; m_div = !m_div; end
        else m_dcnt = m_dcnt + 1;
      end
      if (ld) m_frac = 0;
      else if (m_en) m_frac = fs[31:0];
      m_time = nt;
      if (wr_en) begin
        case (addr)
          4'd0:  m_en = wdata[0];
          4'd2:  m_lo = wdata;
          4'd4:  m_step = wdata[7:0];
          4'd5:  m_add = wdata;
          4'd6:  m_alm0[31:0] = wdata;
          4'd7:  m_alm0[63:32] = wdata;
          4'd8:  m_alm1[31:0] = wdata;
          4'd9:  m_alm1[63:32] = wdata;
          4'd10: m_per = wdata;
          4'd11: m_divn = wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(time_v == m_time, "R2 time", time_v, m_time);
      chk(pulse == m_pulse, "R6 pulse", 64'(pulse), 64'(m_pulse));
      chk(divc == m_div, "R7 divclk", 64'(divc), 64'(m_div));
      chk(alarm == m_flag, "R4 flags", 64'(alarm), 64'(m_flag));
      chk(rdata == mread(addr), "R9 rdata", 64'(rdata), 64'(mread(addr)));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      addr = 4'(i % 13);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] held;
    #(CLK_P*3);
    // R1 reset state
    chk(time_v == 0 && !pulse && !divc && alarm == 0, "R1 reset outputs", time_v, 0);
    for (int a = 0; a < 16; a++) begin
      addr = 4'(a); #1;
      chk(rdata == 0, "R1 reset regs", 64'(rdata), 0);
    end
    @(posedge clk); #1;
    rst_n = 1;
    idle(3);
    chk(time_v == 0, "R1 idle after reset", time_v, 0);

    // R2/R6/R7 basic run
    wr(4'd4, 32'd8);
    wr(4'd5, 32'h4000_0000);
    wr(4'd10, 32'd100);
    wr(4'd11, 32'd6);
    wr(4'd2, 32'h10);
    wr(4'd3, 32'h0);
    chk(time_v == 64'h10, "R3 load value", time_v, 64'h10);
    wr(4'd0, 32'd1);
    idle(60);

    // R4/R5 alarms
    wr(4'd7, 32'd0);
    wr(4'd6, m_time[31:0] + 32'd150);
    idle(40);
    chk(alarm[0] == 1'b1, "R4 alarm0 fired", 64'(alarm), 1);
    chk(alarm[1] == 1'b0, "R5 zero alarm silent", 64'(alarm), 1);
    addr = 4'd1; #1;
    chk(rdata == 32'd1, "R4 event readback", 64'(rdata), 1);
    wr(4'd1, 32'd2);
    chk(alarm[0] == 1'b1, "R5 write zero keeps flag", 64'(alarm), 1);
    wr(4'd1, 32'd1);
    chk(alarm[0] == 1'b0, "R5 w1c clears", 64'(alarm), 0);
    idle(10);
    chk(alarm == 2'b00, "R4 no refire past alarm", 64'(alarm), 0);

    // R8 enable off
    wr(4'd0, 32'd0);
    held = time_v;
    wr(4'd4, 32'd3);
    idle(12);
    chk(time_v == held, "R8 time held", time_v, held);
    chk(!pulse, "R8 no pulse", 64'(pulse), 0);
    addr = 4'd4; #1;
    chk(rdata == 32'd3, "R8 write while off", 64'(rdata), 3);

    // R3 load across word boundary, R7 N=3, alarm1 in high word
    wr(4'd4, 32'd1);
    wr(4'd5, 32'hFFFF_FFFF);
    wr(4'd11, 32'd3);
    wr(4'd10, 32'd37);
    wr(4'd9, 32'd1);
    wr(4'd8, 32'h40);
    wr(4'd2, 32'hFFFF_FF00);
    wr(4'd3, 32'd0);
    chk(time_v == 64'hFFFF_FF00, "R3 staged load", time_v, 64'hFFFF_FF00);
    chk(!divc, "R3 divider realigned", 64'(divc), 0);
    wr(4'd0, 32'd1);
    idle(200);
    chk(alarm[1] == 1'b1, "R4 alarm1 fired", 64'(alarm), 2);
    chk(time_v[63:32] == 32'd1, "R2 carry into high word", time_v, 64'h1_0000_0000);

    // R7 N below 2, R6 period zero
    wr(4'd11, 32'd1);
    idle(5);
    chk(!divc, "R7 N=1 low", 64'(divc), 0);
    wr(4'd11, 32'd0);
    wr(4'd10, 32'd0);
    idle(20);
    chk(!divc && !pulse, "R6 R7 disabled outputs", {divc, pulse}, 0);
    wr(4'd11, 32'd10);
    wr(4'd10, 32'd25);
    wr(4'd4, 32'd5);
    wr(4'd5, 32'h0);
    wr(4'd3, 32'd2);
    idle(80);
    for (int a = 0; a < 16; a++) begin
      @(posedge clk); #1;
      addr = 4'(a);
    end
    idle(2);
    finish_run();
  end
endmodule